// File: doc/BRIEF.md
# Waveform-Mode Timer Counter Channel

A single 16-bit up-counting timer channel for waveform generation and timed events. A mode field picks what the counter counts: one of several divided system-clock enables, a slow-clock enable, or rising edges of a chain input. The chain input is normally fed from the waveform output of another channel, so that two channels can be joined into a wider counter. The channel compares its count against two registers, A and C. A match with A can drive output `wave_a_o` high, and a match with C can drive it low. A match with C also sets a status flag. That flag raises `irq_o` when its interrupt enable is set. Compare C can restart the count and can also stop the clock, which gives a one-shot interval.

Software reaches the channel through a small synchronous register port. Every access takes one cycle. Read data is combinational from the current state while `rd_i` is high. A command register enables the clock, disables it, or fires a software trigger that returns the count to zero.

Register map, by word address:

| Address | Access | Contents |
|---|---|---|
| 0 | write | command: bit0 clock on, bit1 clock off, bit2 trigger |
| 1 | read/write | mode, see R2, R3, R6 and R8 |
| 2 | read/write | compare A |
| 3 | read/write | compare C |
| 4 | read | count |
| 5 | read | status: bit0 compare-C flag (cleared by the read), bit1 clock enabled |
| 6 | write | interrupt enable set |
| 7 | write | interrupt enable clear |
| 8 | read | interrupt enable, bit0 |

Unmapped addresses read as 0.

Top module: `wave_timer_channel`

## Requirements
- R1: While the clock is enabled, the count rises by one on every tick of the selected source. With auto-restart off it wraps from 0xFFFF to 0.
- R2: Mode bits [2:0] select the tick source. Values 0 to 2 pick `div_tick_i[0..2]`, 3 picks `slow_tick_i`, 4 picks a rising edge of `chain_i`, and 5 to 7 give no ticks, so the count holds.
- R3: With mode bit3 (auto-restart) set, a tick that arrives while the count equals compare C loads 0 instead of C+1.
- R4: A tick that arrives while the count equals compare C sets status bit0. Reading address 5 clears it, except when a compare-C match lands in the same cycle as the read; the flag then stays set.
- R5: `irq_o` is high exactly when status bit0 and interrupt-enable bit0 are both set. Writing to address 6 sets the enable bits written as 1. Writing 0xFF to address 7 clears every enable.
- R6: With mode bit4 (stop-on-C) set, a compare-C match clears the clock enable (status bit1 reads 0) and counting stops.
- R7: Command bit0 enables the clock and bit1 disables it. When both are written, disable wins. Bit2 sets the count to 0, and counting resumes on later ticks only if the clock is enabled.
- R8: A compare-A match sets `wave_a_o` when mode bit5 is 1. A compare-C match clears it when mode bit6 is 1. Compare C wins when both match in the same tick. With A=0x0000 and C=0x8000 in free-run mode, the output is a square wave of period 65536 ticks.
- R9: While the clock is disabled, the count holds its value whatever the tick inputs do.
- R10: After reset the count, the mode, the compares, the flags, the enables and `wave_a_o` are all 0. Registers read back through the addresses listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register word address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rd_i | input | 1 | Read strobe (clears the flag when reading status) |
| rdata_o | output | 16 | Read data, valid while rd_i is high |
| div_tick_i | input | 3 | Divided system-clock tick enables |
| slow_tick_i | input | 1 | Slow-clock tick enable |
| chain_i | input | 1 | Chain input, counted on its rising edge |
| wave_a_o | output | 1 | Waveform output A |
| irq_o | output | 1 | Compare-C interrupt |

## Verification
The assertions check the following on every cycle:
- a single count step, the restart to 0, and holding while the clock is disabled;
- the trigger clearing the count;
- disable winning over enable;
- the clock stopping on compare C;
- the flag being set by a match and cleared by a status read;
- the interrupt dropping after the enable is cleared.

Some behaviour needs whole scenarios that only the bench runs:
- source selection, including chain edges and the no-tick codes;
- the full 65536-tick wrap and the square wave on `wave_a_o`;
- a status read that coincides with a restart match;
- the register readback.

The bench compares `wave_a_o` and `irq_o` against its own model on every clock.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int SRC_W  = 3;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CMD   = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_CMPA  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMPC  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CNT   = 4'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd6;
  localparam logic [ADDR_W-1:0] A_IDIS  = 4'd7;
  localparam logic [ADDR_W-1:0] A_IMASK = 4'd8;

  localparam int CMD_ON   = 0;
  localparam int CMD_OFF  = 1;
  localparam int CMD_TRIG = 2;

  typedef struct packed {
    logic             clr_on_c;
    logic             set_on_a;
    logic             stop_on_c;
    logic             auto_c;
    logic [SRC_W-1:0] src;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/wtc_tick_sel.sv
module wtc_tick_sel
  import wtc_pkg::*;
#(
  parameter int NUM_DIV = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SRC_W-1:0]   sel_i,
  input  logic [NUM_DIV-1:0] div_tick_i,
  input  logic               slow_tick_i,
  input  logic               chain_i,
  output logic               tick_o
);
  localparam int SLOTS = 1 << SRC_W;
  localparam int SLOW_SLOT  = NUM_DIV;
  localparam int CHAIN_SLOT = NUM_DIV + 1;

  logic chain_q;
  logic chain_rise;
  logic [SLOTS-1:0] src_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= 1'b0;
    else         chain_q <= chain_i;
  end

  assign chain_rise = chain_i & ~chain_q;

  // slots past the chain slot tie off, giving a no-tick selection
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_DIV) begin : g_div
      assign src_vec[g] = div_tick_i[g];
    end else if (g == SLOW_SLOT) begin : g_slow
      assign src_vec[g] = slow_tick_i;
    end else if (g == CHAIN_SLOT) begin : g_chain
      assign src_vec[g] = chain_rise;
    end else begin : g_none
      assign src_vec[g] = 1'b0;
    end
  end

  assign tick_o = src_vec[sel_i];
endmodule

// File: rtl/wtc_count_core.sv
module wtc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic             auto_i,
  input  logic             set_a_i,
  input  logic             clr_a_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_c_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_c_o,
  output logic             wave_a_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wave_q, wave_d;
  logic             adv, hit_a, hit_c;

  assign adv   = en_i & tick_i & ~trig_i;
  assign hit_a = adv & (cnt_q == cmp_a_i);
  assign hit_c = adv & (cnt_q == cmp_c_i);

  always_comb begin
    cnt_d = cnt_q;
    if (trig_i)                cnt_d = '0;
    else if (hit_c && auto_i)  cnt_d = '0;
    else if (adv)              cnt_d = cnt_q + 1'b1;
  end

  // compare C has priority over compare A on the output
  always_comb begin
    wave_d = wave_q;
    if (hit_c && clr_a_i)      wave_d = 1'b0;
    else if (hit_a && set_a_i) wave_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wave_q <= wave_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign match_c_o = hit_c;
  assign wave_a_o  = wave_q;
endmodule

// File: rtl/wtc_regs.sv
module wtc_regs
  import wtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              rd_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              match_c_i,
  output mode_t             mode_o,
  output logic [CNT_W-1:0]  cmp_a_o,
  output logic [CNT_W-1:0]  cmp_c_o,
  output logic              clk_en_o,
  output logic              trig_o,
  output logic              flag_o,
  output logic              ien_o
);
  mode_t            mode_q;
  logic [CNT_W-1:0] cmp_a_q, cmp_c_q;
  logic             clk_en_q, clk_en_d;
  logic             flag_q, flag_d;
  logic             ien_q, ien_d;
  logic             cmd_wr, stat_rd;

  assign cmd_wr  = wr_i & (addr_i == A_CMD);
  assign stat_rd = rd_i & (addr_i == A_STAT);
  assign trig_o  = cmd_wr & wdata_i[CMD_TRIG];

  always_comb begin
    clk_en_d = clk_en_q;
    if (match_c_i && mode_q.stop_on_c) clk_en_d = 1'b0;
    if (cmd_wr) begin
      if (wdata_i[CMD_OFF])     clk_en_d = 1'b0;
      else if (wdata_i[CMD_ON]) clk_en_d = 1'b1;
    end
  end

  // a match in the read cycle keeps the flag pending
  always_comb begin
    flag_d = flag_q;
    if (match_c_i)    flag_d = 1'b1;
    else if (stat_rd) flag_d = 1'b0;
  end

  always_comb begin
    ien_d = ien_q;
    if (wr_i && addr_i == A_IEN  && wdata_i[0]) ien_d = 1'b1;
    if (wr_i && addr_i == A_IDIS && wdata_i[0]) ien_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      cmp_a_q  <= '0;
      cmp_c_q  <= '0;
      clk_en_q <= 1'b0;
      flag_q   <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      clk_en_q <= clk_en_d;
      flag_q   <= flag_d;
      ien_q    <= ien_d;
      if (wr_i && addr_i == A_MODE) mode_q  <= mode_t'(wdata_i[MODE_W-1:0]);
      if (wr_i && addr_i == A_CMPA) cmp_a_q <= wdata_i;
      if (wr_i && addr_i == A_CMPC) cmp_c_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        A_MODE:  rdata_o = CNT_W'(mode_q);
        A_CMPA:  rdata_o = cmp_a_q;
        A_CMPC:  rdata_o = cmp_c_q;
        A_CNT:   rdata_o = cnt_i;
        A_STAT:  rdata_o = CNT_W'({clk_en_q, flag_q});
        A_IMASK: rdata_o = CNT_W'(ien_q);
        default: rdata_o = '0;
      endcase
    end
  end

  assign mode_o   = mode_q;
  assign cmp_a_o  = cmp_a_q;
  assign cmp_c_o  = cmp_c_q;
  assign clk_en_o = clk_en_q;
  assign flag_o   = flag_q;
  assign ien_o    = ien_q;
endmodule

// File: rtl/wave_timer_channel.sv
module wave_timer_channel
  import wtc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_DIV = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic               rd_i,
  output logic [CNT_W-1:0]   rdata_o,
  input  logic [NUM_DIV-1:0] div_tick_i,
  input  logic               slow_tick_i,
  input  logic               chain_i,
  output logic               wave_a_o,
  output logic               irq_o
);
  mode_t            mode_w;
  logic [CNT_W-1:0] cnt_w, cmp_a_w, cmp_c_w;
  logic             tick_w, clk_en_w, trig_w, match_c_w, flag_w, ien_w;

  wtc_tick_sel #(.NUM_DIV(NUM_DIV)) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (mode_w.src),
    .div_tick_i  (div_tick_i),
    .slow_tick_i (slow_tick_i),
    .chain_i     (chain_i),
    .tick_o      (tick_w)
  );

  wtc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (clk_en_w),
    .tick_i    (tick_w),
    .trig_i    (trig_w),
    .auto_i    (mode_w.auto_c),
    .set_a_i   (mode_w.set_on_a),
    .clr_a_i   (mode_w.clr_on_c),
    .cmp_a_i   (cmp_a_w),
    .cmp_c_i   (cmp_c_w),
    .cnt_o     (cnt_w),
    .match_c_o (match_c_w),
    .wave_a_o  (wave_a_o)
  );

  wtc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .rd_i      (rd_i),
    .rdata_o   (rdata_o),
    .cnt_i     (cnt_w),
    .match_c_i (match_c_w),
    .mode_o    (mode_w),
    .cmp_a_o   (cmp_a_w),
    .cmp_c_o   (cmp_c_w),
    .clk_en_o  (clk_en_w),
    .trig_o    (trig_w),
    .flag_o    (flag_w),
    .ien_o     (ien_w)
  );

  assign irq_o = flag_w & ien_w;
endmodule

// File: rtl/wtc_chk.sv
module wtc_chk
  import wtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic              rd_i,
  input logic              irq_o,
  input mode_t             mode,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp_c,
  input logic              tick,
  input logic              clk_en,
  input logic              trig,
  input logic              match_c,
  input logic              flag
);
  logic cmd_wr, stat_rd, adv;
  assign cmd_wr  = wr_i & (addr_i == A_CMD);
  assign stat_rd = rd_i & (addr_i == A_STAT);
  assign adv     = clk_en & tick & ~trig;

  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && !(mode.auto_c && cnt == cmp_c) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  a_r3_auto_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && mode.auto_c && cnt == cmp_c |=> cnt == '0);

  a_r4_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_c |=> flag);

  a_r4_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd && !match_c |=> !flag);

  a_r5_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == A_IDIS && wdata_i[0] |=> !irq_o);

  a_r6_stop_on_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_c && mode.stop_on_c && !cmd_wr |=> !clk_en);

  a_r7_off_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && wdata_i[CMD_OFF] |=> !clk_en);

  a_r7_trig_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && wdata_i[CMD_TRIG] |=> cnt == '0);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en && !trig |=> $stable(cnt));
endmodule

bind wave_timer_channel wtc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rd_i    (rd_i),
  .irq_o   (irq_o),
  .mode    (mode_w),
  .cnt     (cnt_w),
  .cmp_c   (cmp_c_w),
  .tick    (tick_w),
  .clk_en  (clk_en_w),
  .trig    (trig_w),
  .match_c (match_c_w),
  .flag    (flag_w)
);

// File: tb/wave_timer_channel_tb.sv
module wave_timer_channel_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic        rd_i = 1'b0;
  logic [15:0] rdata_o;
  logic [2:0]  div_tick_i = '0;
  logic        slow_tick_i = 1'b0;
  logic        chain_i = 1'b0;
  logic        wave_a_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  wave_timer_channel u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .div_tick_i(div_tick_i), .slow_tick_i(slow_tick_i), .chain_i(chain_i),
    .wave_a_o(wave_a_o), .irq_o(irq_o)
  );

  // reference model state
  logic [15:0] m_cnt, m_a, m_c;
  logic [6:0]  m_mode;
  bit m_en, m_flag, m_wave, m_ien, m_chain_prev;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_a = 0; m_c = 0; m_mode = 0;
      m_en = 0; m_flag = 0; m_wave = 0; m_ien = 0; m_chain_prev = 0;
    end else begin
      bit tk, trig, adv, mc, ma, cmd;
      int src;
      src = int'(m_mode[2:0]);
      if (src < 3)       tk = div_tick_i[src];
      else if (src == 3) tk = slow_tick_i;
      else if (src == 4) tk = chain_i && !m_chain_prev;
      else               tk = 0;
      m_chain_prev = chain_i;
      cmd  = wr_i && addr_i == 0;
      trig = cmd && wdata_i[2];
      adv  = m_en && tk && !trig;
      mc   = adv && m_cnt == m_c;
      ma   = adv && m_cnt == m_a;
      if (trig) m_cnt = 0;
      else if (mc && m_mode[3]) m_cnt = 0;
      else if (adv) m_cnt = m_cnt + 16'd1;
      if (mc && m_mode[4]) m_en = 0;
      if (cmd) begin
        if (wdata_i[1]) m_en = 0;
        else if (wdata_i[0]) m_en = 1;
      end
      if (mc) m_flag = 1;
      else if (rd_i && addr_i == 5) m_flag = 0;
      if (mc && m_mode[6]) m_wave = 0;
      else if (ma && m_mode[5]) m_wave = 1;
      if (wr_i) begin
        case (addr_i)
          1: m_mode = wdata_i[6:0];
          2: m_a = wdata_i;
          3: m_c = wdata_i;
          6: if (wdata_i[0]) m_ien = 1;
          7: if (wdata_i[0]) m_ien = 0;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] m_read(logic [3:0] a);
    case (a)
      1: return {9'd0, m_mode};
      2: return m_a;
      3: return m_c;
      4: return m_cnt;
      5: return {14'd0, m_en, m_flag};
      8: return {15'd0, m_ien};
      default: return 16'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tick sources
  always @(negedge clk_i) begin
    cyc++;
    div_tick_i[0] <= 1'b1;
    div_tick_i[1] <= cyc[0];
    div_tick_i[2] <= (cyc % 8) == 0;
    slow_tick_i   <= (cyc % 16) == 0;
    chain_i       <= ((cyc / 3) % 2) == 1;
  end

  // per-cycle comparison of outputs
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R8 wave_a_o", {15'd0, wave_a_o}, {15'd0, m_wave});
      chk("R5 irq_o", {15'd0, irq_o}, {15'd0, m_flag & m_ien});
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic rd(string req, logic [3:0] a);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1;
    chk(req, rdata_o, m_read(a));
    @(posedge clk_i); #1;
    rd_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10 reset state
    rd("R10 count reset", 4);
    rd("R10 status reset", 5);
    rd("R10 mode reset", 1);
    rd("R10 mask reset", 8);
    chk("R10 wave reset", {15'd0, wave_a_o}, 16'd0);

    // R8/R1 square wave, free run, wrap
    wr(2, 16'h0000);
    wr(3, 16'h8000);
    wr(1, 16'h0060);
    rd("R10 mode readback", 1);
    rd("R10 cmpc readback", 3);
    wr(0, 16'h0005);
    idle(40000);
    rd("R1 free count", 4);
    idle(30000);
    rd("R1 wrap past 0xFFFF", 4);

    // R3 auto restart at C on div source 1
    wr(3, 16'd5);
    wr(1, 16'h0009);
    wr(0, 16'h0005);
    for (int i = 0; i < 6; i++) begin
      idle(3);
      rd("R3 auto restart count", 4);
    end

    // R4/R5 flag and interrupt
    wr(6, 16'h0001);
    rd("R5 mask set", 8);
    idle(20);
    chk("R5 irq asserted", {15'd0, irq_o}, 16'd1);
    wr(1, 16'h0008); // div 0, restart every 6 ticks
    for (int i = 0; i < 8; i++) rd("R4 clear-on-read", 5);
    wr(7, 16'h00FF);
    rd("R5 all masked", 8);
    idle(2);
    chk("R5 irq low when masked", {15'd0, irq_o}, 16'd0);

    // R6 one-shot on slow clock
    wr(3, 16'd3);
    wr(1, 16'h001B);
    wr(0, 16'h0005);
    rd("R6 running", 5);
    idle(120);
    rd("R6 stopped after compare C", 5);
    rd("R6 count after stop", 4);

    // R7 commands
    wr(1, 16'h0000);
    wr(0, 16'h0001);
    rd("R7 enable", 5);
    wr(0, 16'h0003);
    rd("R7 disable wins", 5);
    idle(10);
    rd("R9 hold while disabled", 4);
    idle(40);
    rd("R9 still held", 4);
    wr(0, 16'h0004);
    rd("R7 trigger clears count", 4);
    idle(10);
    rd("R7 no count after trigger when off", 4);

    // R2 source selection
    wr(1, 16'h0004);
    wr(0, 16'h0005);
    idle(50);
    rd("R2 chain edges", 4);
    wr(1, 16'h0002);
    idle(40);
    rd("R2 div source 2", 4);
    wr(1, 16'h0003);
    idle(40);
    rd("R2 slow source", 4);
    wr(1, 16'h0007);
    rd("R2 no-tick code", 4);
    idle(30);
    rd("R2 no-tick holds", 4);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule